// File: doc/BRIEF.md
# Calendar Real-Time Clock

This peripheral keeps a running calendar of century, year, month, day, hour, minute and second. An external one-pulse-per-second strobe advances it. Software reaches it through a small synchronous 32-bit register port. The live time is split across two packed counter words. A control word holds an enable bit and an unlock bit. The enable bit decides whether counter reads show the running time or the last stored word. The unlock bit decides whether writes to the counter words are taken.

Every accepted write to a counter word or to the control word reloads the running time from the stored counter words. Counting then carries on from that point. The carry chain handles month lengths and the Gregorian leap-year rule. While enabled, a counter read also copies the live value into the stored word. A later read with the enable bit clear therefore returns the time of the last enabled read.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, every stored word (both counter words, control) and the running time are zero, and reads of the control word and of both counter words return 0.
- R2: The low counter word (byte offset 0x00) packs second in bits 5:0, minute in bits 13:8, hour in bits 20:16 and day of month in bits 28:24; when the running time is read, all other bits read 0.
- R3: The high counter word (byte offset 0x04) packs month (1 to 12) in bits 3:0, year within the century (0 to 99) in bits 14:8 and century in bits 20:16; when the running time is read, all other bits read 0.
- R4: With control bit 0 (enable) set, a counter read returns the running time and copies it into that stored word. With enable clear, the read returns the stored word unchanged.
- R5: A write to a counter word is discarded unless control bit 1 (unlock) is set. A write to the control word (byte offset 0x10) is always stored in full.
- R6: An accepted counter write or any control write loads the running time from the fields of the stored counter words, including the newly written value.
- R7: Reads of offsets 0x08, 0x0C, 0x14 and any offset outside the three mapped words return 0. Writes there change no stored word and not the running time.
- R8: Each tick adds one second. Seconds wrap 59 to 0 into minutes, minutes wrap 59 to 0 into hours, and hours wrap 23 to 0 into the day.
- R9: A tick on the last day of a month at 23:59:59 moves to day 1 of the next month. From December it moves to January with the year increased. Year 99 wraps to 0 with the century increased.
- R10: February has 29 days when the full year (century × 100 + year) is divisible by 4, except century years not divisible by 400; otherwise 28.
- R11: Read data appears on the port one clock edge after the read strobe and holds until the next read.
- R12: When a load (R6) and a tick fall in the same cycle, the load wins and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| rd_en | input | 1 | Read strobe for the word at `addr` |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
A wrong carry or month-length decision shows at the ports on the first counter read after the faulty tick: a day past the end of the month, a missed month or year step, or a February of the wrong length. The bench sweeps every month end across plain, leap and century years, and reads back both words after each tick. A lock-gating or reload fault shows on the next enabled read, as a running time that moved when it should not have or failed to return to the stored value.

// File: rtl/rtc_calendar_pkg.sv
package rtc_calendar_pkg;

    localparam int WORD_W   = 32;
    localparam int IDX_LO   = 0;
    localparam int IDX_HI   = 1;
    localparam int IDX_CTRL = 4;
    localparam int CTRL_EN  = 0;
    localparam int CTRL_UNL = 1;

    typedef struct packed {
        logic [4:0] cent;
        logic [6:0] year;
        logic [3:0] month;
        logic [4:0] day;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } cal_time_t;

    function automatic logic [WORD_W-1:0] pack_lo(cal_time_t t);
        logic [WORD_W-1:0] w;
        w        = '0;
        w[28:24] = t.day;
        w[20:16] = t.hour;
        w[13:8]  = t.min;
        w[5:0]   = t.sec;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] pack_hi(cal_time_t t);
        logic [WORD_W-1:0] w;
        w        = '0;
        w[20:16] = t.cent;
        w[14:8]  = t.year;
        w[3:0]   = t.month;
        return w;
    endfunction

    function automatic cal_time_t unpack(logic [WORD_W-1:0] lo, logic [WORD_W-1:0] hi);
        cal_time_t t;
        t.day   = lo[28:24];
        t.hour  = lo[20:16];
        t.min   = lo[13:8];
        t.sec   = lo[5:0];
        t.cent  = hi[20:16];
        t.year  = hi[14:8];
        t.month = hi[3:0];
        return t;
    endfunction

endpackage

// File: rtl/rtc_month_len.sv
module rtc_month_len (
    input  logic [3:0] month,
    input  logic [6:0] year,
    input  logic [4:0] cent,
    output logic [4:0] last_day
);
    logic leap;

    // century*100 is a multiple of 4, so only the year field matters for
    // divisibility by 4; at year 0 the century decides the 400 rule.
    always_comb begin
        if (year == 7'd0) begin
            leap = (cent[1:0] == 2'b00);
        end else begin
            leap = (year[1:0] == 2'b00);
        end
    end

    always_comb begin
        case (month)
            4'd2:                      last_day = leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   last_day = 5'd30;
            default:                   last_day = 5'd31;
        endcase
    end
endmodule

// File: rtl/rtc_advance.sv
module rtc_advance
    import rtc_calendar_pkg::*;
(
    input  cal_time_t cur,
    output cal_time_t nxt
);
    logic [4:0] last_day;
    logic       c_sec, c_min, c_hour, c_day, c_mon, c_year;

    rtc_month_len u_len (
        .month    (cur.month),
        .year     (cur.year),
        .cent     (cur.cent),
        .last_day (last_day)
    );

    always_comb begin
        c_sec  = (cur.sec   >= 6'd59);
        c_min  = c_sec  && (cur.min   >= 6'd59);
        c_hour = c_min  && (cur.hour  >= 5'd23);
        c_day  = c_hour && (cur.day   >= last_day);
        c_mon  = c_day  && (cur.month >= 4'd12);
        c_year = c_mon  && (cur.year  >= 7'd99);

        nxt.sec   = c_sec  ? 6'd0 : 6'(cur.sec + 6'd1);
        nxt.min   = c_min  ? 6'd0 : (c_sec  ? 6'(cur.min   + 6'd1) : cur.min);
        nxt.hour  = c_hour ? 5'd0 : (c_min  ? 5'(cur.hour  + 5'd1) : cur.hour);
        nxt.day   = c_day  ? 5'd1 : (c_hour ? 5'(cur.day   + 5'd1) : cur.day);
        nxt.month = c_mon  ? 4'd1 : (c_day  ? 4'(cur.month + 4'd1) : cur.month);
        nxt.year  = c_year ? 7'd0 : (c_mon  ? 7'(cur.year  + 7'd1) : cur.year);
        nxt.cent  = c_year ? 5'(cur.cent + 5'd1) : cur.cent;
    end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_calendar_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata
);
    localparam int IDX_W = ADDR_W - 2;

    typedef struct packed {
        logic [WORD_W-1:0] lo;
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] ctrl;
        logic [WORD_W-1:0] rdata;
        cal_time_t         live;
    } rtc_state_t;

    rtc_state_t s_d, s_q;
    cal_time_t  adv;
    logic [IDX_W-1:0] idx;
    logic sel_lo, sel_hi, sel_ctrl, mapped;
    logic lo_acc, hi_acc, ctrl_acc, load;

    rtc_advance u_adv (
        .cur (s_q.live),
        .nxt (adv)
    );

    always_comb begin
        idx      = addr[ADDR_W-1:2];
        sel_lo   = (idx == IDX_W'(IDX_LO));
        sel_hi   = (idx == IDX_W'(IDX_HI));
        sel_ctrl = (idx == IDX_W'(IDX_CTRL));
        mapped   = sel_lo || sel_hi || sel_ctrl;
        lo_acc   = wr_en && sel_lo && s_q.ctrl[CTRL_UNL];
        hi_acc   = wr_en && sel_hi && s_q.ctrl[CTRL_UNL];
        ctrl_acc = wr_en && sel_ctrl;
        load     = lo_acc || hi_acc || ctrl_acc;
    end

    always_comb begin
        s_d = s_q;

        if (rd_en) begin
            if (sel_lo) begin
                if (s_q.ctrl[CTRL_EN]) begin
                    s_d.lo    = pack_lo(s_q.live);
                    s_d.rdata = pack_lo(s_q.live);
                end else begin
                    s_d.rdata = s_q.lo;
                end
            end else if (sel_hi) begin
                if (s_q.ctrl[CTRL_EN]) begin
                    s_d.hi    = pack_hi(s_q.live);
                    s_d.rdata = pack_hi(s_q.live);
                end else begin
                    s_d.rdata = s_q.hi;
                end
            end else if (sel_ctrl) begin
                s_d.rdata = s_q.ctrl;
            end else begin
                s_d.rdata = '0;
            end
        end

        if (lo_acc)   s_d.lo   = wdata;
        if (hi_acc)   s_d.hi   = wdata;
        if (ctrl_acc) s_d.ctrl = wdata;

        if (load) begin
            s_d.live = unpack(s_d.lo, s_d.hi);
        end else if (sec_tick) begin
            s_d.live = adv;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata = s_q.rdata;

    AST_LOCKED_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_lo && !s_q.ctrl[CTRL_UNL] && !rd_en) |=> $stable(s_q.lo)); // R5

    AST_CTRL_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_ctrl) |=> (s_q.ctrl == $past(wdata))); // R5

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !mapped) |=> (rdata == '0)); // R7

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !wr_en && s_q.live.sec == 6'd59) |=> (s_q.live.sec == 6'd0)); // R8

    AST_LOAD_BEATS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_ctrl && !rd_en) |=> (s_q.live == unpack($past(s_q.lo), $past(s_q.hi)))); // R12

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en) |=> $stable(rdata)); // R11
endmodule

// File: tb/rtc_calendar_bench.sv
module rtc_calendar_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int n_cmp = 0;
    int n_bad = 0;

    int m_cent, m_year, m_mon, m_day, m_hour, m_min, m_sec;

    always #10 clk = ~clk;

    rtc_calendar #(.ADDR_W(5)) u_rtc_calendar (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .rd_en(rd_en),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic do_tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    function automatic int b_dim(int mon, int full);
        bit leap;
        leap = ((full % 4 == 0) && (full % 100 != 0)) || (full % 400 == 0);
        if (mon == 2) return leap ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [31:0] b_lo(int d, int h, int mi, int s);
        return (32'(d) << 24) | (32'(h) << 16) | (32'(mi) << 8) | 32'(s);
    endfunction

    function automatic logic [31:0] b_hi(int c, int y, int mo);
        return (32'(c) << 16) | (32'(y) << 8) | 32'(mo);
    endfunction

    task automatic model_step();
        m_sec++;
        if (m_sec == 60) begin m_sec = 0; m_min++; end
        if (m_min == 60) begin m_min = 0; m_hour++; end
        if (m_hour == 24) begin m_hour = 0; m_day++; end
        if (m_day > b_dim(m_mon, m_cent * 100 + m_year)) begin m_day = 1; m_mon++; end
        if (m_mon == 13) begin m_mon = 1; m_year++; end
        if (m_year == 100) begin m_year = 0; m_cent = (m_cent + 1) % 32; end
    endtask

    task automatic set_time(int c, int y, int mo, int d, int h, int mi, int s);
        do_write(5'h10, 32'h3);
        do_write(5'h00, b_lo(d, h, mi, s));
        do_write(5'h04, b_hi(c, y, mo));
        m_cent = c; m_year = y; m_mon = mo; m_day = d;
        m_hour = h; m_min = mi; m_sec = s;
    endtask

    task automatic check_live(string req);
        logic [31:0] v;
        do_read(5'h00, v);
        check(req, v, b_lo(m_day, m_hour, m_min, m_sec));
        do_read(5'h04, v);
        check(req, v, b_hi(m_cent, m_year, m_mon));
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int full_years[8] = '{1900, 1999, 2000, 2023, 2024, 2099, 2100, 2400};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        do_read(5'h10, v); check("R1 ctrl", v, 32'h0);
        do_read(5'h00, v); check("R1 lo", v, 32'h0);
        do_read(5'h04, v); check("R1 hi", v, 32'h0);

        // R7: alarm, alarm status, gap offsets read zero
        do_read(5'h08, v); check("R7 off08", v, 32'h0);
        do_read(5'h0C, v); check("R7 off0C", v, 32'h0);
        do_read(5'h14, v); check("R7 off14", v, 32'h0);
        do_read(5'h1C, v); check("R7 off1C", v, 32'h0);

        // R5/R6/R4: unlocked but disabled
        do_write(5'h10, 32'h2);
        do_read(5'h10, v); check("R5 R11 ctrl readback", v, 32'h2);
        do_write(5'h00, b_lo(15, 10, 20, 30));
        do_write(5'h04, b_hi(20, 24, 2));
        repeat (3) do_tick();
        do_read(5'h00, v); check("R4 disabled lo stored", v, b_lo(15, 10, 20, 30));
        do_read(5'h04, v); check("R4 disabled hi stored", v, b_hi(20, 24, 2));
        do_write(5'h10, 32'h3);  // reload from stored words
        do_read(5'h00, v); check("R6 reload on ctrl write", v, b_lo(15, 10, 20, 30));
        repeat (2) do_tick();
        do_read(5'h00, v); check("R4 R8 enabled live", v, b_lo(15, 10, 20, 32));

        // R5: locked counter write dropped
        do_write(5'h10, 32'h1);
        do_write(5'h00, b_lo(1, 2, 3, 4));
        do_write(5'h04, b_hi(1, 1, 1));
        do_read(5'h00, v); check("R5 locked lo", v, b_lo(15, 10, 20, 32));
        do_read(5'h04, v); check("R5 locked hi", v, b_hi(20, 24, 2));

        // R7: write to alarm offsets has no effect
        do_write(5'h08, 32'hFFFF_FFFF);
        do_write(5'h14, 32'hFFFF_FFFF);
        do_read(5'h08, v); check("R7 write ignored 08", v, 32'h0);
        do_read(5'h00, v); check("R7 live unchanged", v, b_lo(15, 10, 20, 32));

        // R4: disabled read shows value captured by last enabled read
        do_tick();
        do_write(5'h10, 32'h0);
        do_read(5'h00, v); check("R4 stored from last enabled read", v, b_lo(15, 10, 20, 32));
        do_write(5'h10, 32'h1);
        do_read(5'h00, v); check("R6 ctrl reload drops tick", v, b_lo(15, 10, 20, 32));

        // R2/R3: field positions with all-ones stores
        do_write(5'h10, 32'h3);
        do_write(5'h00, 32'hFFFF_FFFF);
        do_write(5'h04, 32'hFFFF_FFFF);
        do_read(5'h00, v); check("R2 lo fields", v, 32'h1F1F_3F3F);
        do_read(5'h04, v); check("R3 hi fields", v, 32'h001F_7F0F);

        // R12: load and tick in the same cycle
        @(negedge clk);
        wr_en = 1'b1; addr = 5'h00; wdata = b_lo(9, 8, 7, 6); sec_tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; sec_tick = 1'b0;
        do_read(5'h00, v); check("R12 load wins over tick", v, b_lo(9, 8, 7, 6));

        // R9/R10: month-end sweep over plain, leap and century years
        foreach (full_years[i]) begin
            for (int mo = 1; mo <= 12; mo++) begin
                int c = full_years[i] / 100;
                int y = full_years[i] % 100;
                set_time(c, y, mo, b_dim(mo, full_years[i]), 23, 59, 59);
                do_tick(); model_step();
                check_live("R9 month end");
                if (mo == 2) begin
                    set_time(c, y, 2, 28, 23, 59, 59);
                    do_tick(); model_step();
                    check_live("R10 february 28");
                end
            end
        end

        // R8: continuous run across minute, hour, day and leap month
        set_time(20, 24, 2, 28, 23, 58, 30);
        for (int k = 0; k < 100; k++) begin
            do_tick(); model_step();
            check_live("R8 carry chain");
        end

        finish_run();
    end
endmodule